// File: doc/BRIEF.md
# UART Status and Interrupt Controller

This block sits between a CPU register port and the shift engines of one UART channel. It holds one received byte and one byte waiting to be sent. It keeps the receive error flags and the buffer-state flags, and it presents them in a 16-bit status word whose bit positions are fixed. From those flags it drives a receive interrupt line and a transmit interrupt line. The baud generator, line sampling and the shift registers are outside the block.

The receive engine offers a finished byte with a one-cycle load strobe, together with parity and framing error strobes for that byte. The block detects overrun itself. The transmit engine sees the pending byte through a valid/take pair and takes it when sending begins.

Bit order is handled at the register port, not in the shifters. The shifters always work LSB first. When MSB-first order is selected, the block mirrors the byte when the CPU writes the transmit register, and mirrors it again when the CPU reads the receive register. The selection in force at the moment of each access is the one that applies. A byte already stored is therefore misordered if the selection changes before that byte is used.

Top module: `uart_stat_ctrl`

## Requirements
- R1: After reset the status word is 16'h0800: only transmit-empty is set. Both interrupt lines and `tx_valid` are 0, and the receiver and all enables are off.
- R2: Status bit positions are: 15 parity error, 14 overrun, 13 framing error, 12 receive full, 11 transmit empty, 10 MSB-first select, 9 receive interrupt enable, 8 transmit interrupt enable. Bits 7..0 read 0. The control write fields are `ctrl_wdata[0]` receiver enable, `[1]` MSB-first, `[2]` receive interrupt enable and `[3]` transmit interrupt enable.
- R3: An accepted `rx_load` stores `rx_byte` and sets receive full from the next cycle. An `rx_rd` with no load clears receive full from the next cycle.
- R4: An accepted `rx_load` while receive full is 1 and no `rx_rd` is present sets overrun. The held byte is kept, and the new byte and its error strobes are discarded.
- R5: An `rx_rd` in the same cycle as an accepted `rx_load` resolves in favour of the load. Receive full stays 1, the new byte is held, and no overrun is flagged.
- R6: The parity and framing flags are set by their strobes on an accepted, non-overrun load. All three error flags stay set until a control write with receiver enable 0, which clears them from the next cycle. That clear beats any set in the same cycle.
- R7: While the receiver enable is 0, `rx_load` has no effect on the held byte or on any flag.
- R8: A CPU transmit write clears transmit-empty and presents the byte on `tx_data` with `tx_valid` high. `tx_take` while `tx_valid` is high sets transmit-empty. A write in the same cycle as a take leaves transmit-empty at 0 and presents the newly written byte.
- R9: `rx_irq` is 1 exactly when the receive interrupt enable is 1 and at least one of receive full, parity, overrun or framing is 1.
- R10: `tx_irq` is 1 exactly when the transmit interrupt enable is 1 and transmit-empty is 1.
- R11: With MSB-first set at access time, a transmit write stores the bit-mirrored byte and `rx_rdata` shows the bit-mirrored held byte. With it clear, both pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 4 | Control write data (receiver enable, MSB-first, receive IE, transmit IE) |
| rx_rd | input | 1 | CPU read strobe for the receive data register |
| rx_rdata | output | 8 | Receive data as seen by the CPU (order applied) |
| tx_we | input | 1 | CPU write strobe for the transmit data register |
| tx_wdata | input | 8 | CPU transmit data |
| tx_data | output | 8 | Byte offered to the transmit shifter (LSB-first form) |
| tx_valid | output | 1 | Transmit register holds a byte |
| tx_take | input | 1 | Transmit shifter loads the byte and starts sending |
| rx_load | input | 1 | Receive shifter has a finished byte |
| rx_byte | input | 8 | Received byte in LSB-first form |
| rx_par_err | input | 1 | Parity error for the byte on rx_load |
| rx_frm_err | input | 1 | Framing error for the byte on rx_load |
| status | output | 16 | Status word |
| rx_irq | output | 1 | Receive interrupt request |
| tx_irq | output | 1 | Transmit interrupt request |

## Verification
Each flag, the held receive byte and the transmit byte are registered. A strobe sampled at one rising edge is therefore visible on `status`, `tx_data` and `tx_valid` after that edge. `rx_irq`, `tx_irq` and `rx_rdata` are combinational from that registered state, so they move in the same cycle as the status bits they depend on. The bench drives every input 1 ns after a rising edge and holds it for exactly one cycle. It compares all outputs 1 ns after the following rising edge against a reference model that it advances once per cycle. This way every result is sampled in the first cycle it is due and never near an edge.

// File: rtl/uart_stat_pkg.sv
// Package: shared widths, status bit positions and the control field layout
// for the UART status and interrupt controller.
package uart_stat_pkg;

    localparam int DATA_W = 8;
    localparam int STAT_W = 16;
    localparam int CTRL_W = 4;

    // Status word bit positions (software decodes these).
    localparam int ST_PAR  = 15;
    localparam int ST_OVR  = 14;
    localparam int ST_FRM  = 13;
    localparam int ST_FULL = 12;
    localparam int ST_EMPT = 11;
    localparam int ST_MSBF = 10;
    localparam int ST_RIE  = 9;
    localparam int ST_TIE  = 8;

    // Control register, packed so that bit 0 is receiver enable.
    typedef struct packed {
        logic tx_ie;      // bit 3
        logic rx_ie;      // bit 2
        logic msb_first;  // bit 1
        logic rx_en;      // bit 0
    } ctrl_t;

endpackage

// File: rtl/uart_bit_order.sv
// Module: uart_bit_order
// Mirrors a data word end for end when 'mirror' is high, else passes it on.
// Assumes: purely combinational; used on both CPU write and CPU read paths.
module uart_bit_order #(
    parameter int W = 8
) (
    input  logic         mirror,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] flipped;

    // Build the mirrored word one wire per bit.
    for (genvar i = 0; i < W; i++) begin : g_flip
        assign flipped[i] = din[W-1-i];
    end

    // Select between straight and mirrored forms.
    always_comb begin
        dout = mirror ? flipped : din;
    end

endmodule

// File: rtl/uart_rx_hold.sv
// Module: uart_rx_hold
// Holds one received byte, its full flag and the three sticky error flags.
// Assumes: 'load' is already gated by the receiver enable; 'clr_err' is one
// cycle wide and takes priority over any error set in the same cycle.
module uart_rx_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] byte_in,
    input  logic         par_err,
    input  logic         frm_err,
    input  logic         rd,
    input  logic         clr_err,
    output logic [W-1:0] data_o,
    output logic         full_o,
    output logic         pe_o,
    output logic         ore_o,
    output logic         fre_o
);

    logic [W-1:0] data_q;
    logic         full_q;
    logic         pe_q;
    logic         ore_q;
    logic         fre_q;
    logic         overrun;
    logic         accept;

    // Decide whether an incoming byte is stored or lost to overrun.
    always_comb begin
        overrun = load && full_q && !rd;
        accept  = load && !overrun;
    end

    // Byte register and full flag; a load beats a read in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            full_q <= 1'b0;
        end else if (accept) begin
            data_q <= byte_in;
            full_q <= 1'b1;
        end else if (rd) begin
            full_q <= 1'b0;
        end
    end

    // Sticky error flags, cleared only by the receiver-disable write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pe_q  <= 1'b0;
            ore_q <= 1'b0;
            fre_q <= 1'b0;
        end else if (clr_err) begin
            pe_q  <= 1'b0;
            ore_q <= 1'b0;
            fre_q <= 1'b0;
        end else begin
            if (overrun)            ore_q <= 1'b1;
            if (accept && par_err)  pe_q  <= 1'b1;
            if (accept && frm_err)  fre_q <= 1'b1;
        end
    end

    assign data_o = data_q;
    assign full_o = full_q;
    assign pe_o   = pe_q;
    assign ore_o  = ore_q;
    assign fre_o  = fre_q;

    AST_OVERRUN_KEEPS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (load && full_o && !rd && !clr_err) |=> (ore_o && $stable(data_o))); // R4
    AST_LOAD_BEATS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (load && rd) |=> full_o); // R5
    AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !load) |=> !full_o); // R3
    AST_CLEAR_ERRORS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_err |=> !(pe_o || ore_o || fre_o)); // R6
    AST_ERRORS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_err && (pe_o || ore_o || fre_o)) |=> (pe_o || ore_o || fre_o)); // R6

endmodule

// File: rtl/uart_tx_hold.sv
// Module: uart_tx_hold
// Holds one byte for the transmit shifter and its empty flag.
// Assumes: 'wdata' is already in shifter (LSB-first) order; a CPU write in
// the same cycle as a take replaces the byte and leaves the register occupied.
module uart_tx_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         take,
    output logic [W-1:0] data_o,
    output logic         empty_o
);

    logic [W-1:0] data_q;
    logic         empty_q;

    // Byte register and empty flag; a write outranks a take.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= '0;
            empty_q <= 1'b1;
        end else if (wr) begin
            data_q  <= wdata;
            empty_q <= 1'b0;
        end else if (take && !empty_q) begin
            empty_q <= 1'b1;
        end
    end

    assign data_o  = data_q;
    assign empty_o = empty_q;

    AST_WRITE_OCCUPIES: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (!empty_o && data_o == $past(wdata))); // R8
    AST_TAKE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !empty_o && !wr) |=> empty_o); // R8

endmodule

// File: rtl/uart_stat_ctrl.sv
// Module: uart_stat_ctrl (top)
// Status, data holding and interrupt logic for one UART channel.
// Assumes: shifters work LSB first; MSB-first order is applied here at the
// CPU access; one rx_load strobe per finished byte.
module uart_stat_ctrl
    import uart_stat_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int SW = STAT_W,
    parameter int CW = CTRL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctrl_we,
    input  logic [CW-1:0] ctrl_wdata,
    input  logic          rx_rd,
    output logic [DW-1:0] rx_rdata,
    input  logic          tx_we,
    input  logic [DW-1:0] tx_wdata,
    output logic [DW-1:0] tx_data,
    output logic          tx_valid,
    input  logic          tx_take,
    input  logic          rx_load,
    input  logic [DW-1:0] rx_byte,
    input  logic          rx_par_err,
    input  logic          rx_frm_err,
    output logic [SW-1:0] status,
    output logic          rx_irq,
    output logic          tx_irq
);

    ctrl_t         ctrl_q;
    ctrl_t         ctrl_in;
    logic          clr_err;
    logic          rx_accept;
    logic [DW-1:0] rx_held;
    logic          rx_full;
    logic          pe;
    logic          ore;
    logic          fre;
    logic [DW-1:0] tx_ordered;
    logic          tx_empty;

    // Decode the control write and the receive gating.
    always_comb begin
        ctrl_in   = ctrl_t'(ctrl_wdata);
        clr_err   = ctrl_we && !ctrl_in.rx_en;
        rx_accept = rx_load && ctrl_q.rx_en;
    end

    // Control register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_we) begin
            ctrl_q <= ctrl_in;
        end
    end

    uart_rx_hold #(.W(DW)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (rx_accept),
        .byte_in (rx_byte),
        .par_err (rx_par_err),
        .frm_err (rx_frm_err),
        .rd      (rx_rd),
        .clr_err (clr_err),
        .data_o  (rx_held),
        .full_o  (rx_full),
        .pe_o    (pe),
        .ore_o   (ore),
        .fre_o   (fre)
    );

    uart_bit_order #(.W(DW)) u_rd_order (
        .mirror (ctrl_q.msb_first),
        .din    (rx_held),
        .dout   (rx_rdata)
    );

    uart_bit_order #(.W(DW)) u_wr_order (
        .mirror (ctrl_q.msb_first),
        .din    (tx_wdata),
        .dout   (tx_ordered)
    );

    uart_tx_hold #(.W(DW)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (tx_we),
        .wdata   (tx_ordered),
        .take    (tx_take),
        .data_o  (tx_data),
        .empty_o (tx_empty)
    );

    // Assemble the status word and the interrupt requests.
    always_comb begin
        status          = '0;
        status[ST_PAR]  = pe;
        status[ST_OVR]  = ore;
        status[ST_FRM]  = fre;
        status[ST_FULL] = rx_full;
        status[ST_EMPT] = tx_empty;
        status[ST_MSBF] = ctrl_q.msb_first;
        status[ST_RIE]  = ctrl_q.rx_ie;
        status[ST_TIE]  = ctrl_q.tx_ie;
        tx_valid        = !tx_empty;
        rx_irq          = ctrl_q.rx_ie && (rx_full || pe || ore || fre);
        tx_irq          = ctrl_q.tx_ie && tx_empty;
    end

    AST_DISABLED_IGNORES_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_load && !ctrl_q.rx_en && !rx_rd) |=> $stable(rx_held)); // R7
    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (status == 16'h0800 && !rx_irq && !tx_irq)); // R1

endmodule

// File: tb/uart_stat_ctrl_bench.sv
`timescale 1ns/1ps
module uart_stat_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_we = 1'b0;
    logic [3:0]  ctrl_wdata = '0;
    logic        rx_rd = 1'b0;
    logic [7:0]  rx_rdata;
    logic        tx_we = 1'b0;
    logic [7:0]  tx_wdata = '0;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic        tx_take = 1'b0;
    logic        rx_load = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_par_err = 1'b0;
    logic        rx_frm_err = 1'b0;
    logic [15:0] status;
    logic        rx_irq;
    logic        tx_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    bit       m_full, m_pe, m_ore, m_fre, m_tdre, m_en, m_msb, m_rie, m_tie;
    bit [7:0] m_data, m_txd;

    always #2 clk = ~clk;

    uart_stat_ctrl u_uart_stat_ctrl (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .rx_rd(rx_rd), .rx_rdata(rx_rdata), .tx_we(tx_we), .tx_wdata(tx_wdata),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_take(tx_take),
        .rx_load(rx_load), .rx_byte(rx_byte), .rx_par_err(rx_par_err),
        .rx_frm_err(rx_frm_err), .status(status), .rx_irq(rx_irq), .tx_irq(tx_irq)
    );

    function automatic bit [7:0] mirror8(input bit [7:0] v);
        bit [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = v[7-i];
        return r;
    endfunction

    function automatic bit [15:0] exp_status();
        return {m_pe, m_ore, m_fre, m_full, m_tdre, m_msb, m_rie, m_tie, 8'h00};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_all();
        check("R2", "status", status, exp_status());
        check("R9", "rx_irq", {15'd0, rx_irq}, {15'd0, m_rie & (m_full | m_pe | m_ore | m_fre)});
        check("R10", "tx_irq", {15'd0, tx_irq}, {15'd0, m_tie & m_tdre});
        check("R8", "tx_valid", {15'd0, tx_valid}, {15'd0, !m_tdre});
        check("R8", "tx_data", {8'd0, tx_data}, {8'd0, m_txd});
        check("R11", "rx_rdata", {8'd0, rx_rdata}, {8'd0, m_msb ? mirror8(m_data) : m_data});
    endtask

    // One cycle of stimulus; the model advances with the same rules.
    task automatic apply(input bit cwe, input bit [3:0] cd, input bit rd,
                         input bit wr, input bit [7:0] wd, input bit ld,
                         input bit [7:0] lb, input bit pe, input bit fe, input bit tk);
        bit clr, acc, ovr;
        ctrl_we = cwe; ctrl_wdata = cd; rx_rd = rd; tx_we = wr; tx_wdata = wd;
        rx_load = ld; rx_byte = lb; rx_par_err = pe; rx_frm_err = fe; tx_take = tk;
        clr = cwe && !cd[0];
        acc = ld && m_en;
        ovr = acc && m_full && !rd;
        if (acc && !ovr) begin m_data = lb; m_full = 1; end
        else if (rd) m_full = 0;
        if (clr) begin m_pe = 0; m_ore = 0; m_fre = 0; end
        else begin
            if (ovr) m_ore = 1;
            if (acc && !ovr && pe) m_pe = 1;
            if (acc && !ovr && fe) m_fre = 1;
        end
        if (wr) begin m_txd = m_msb ? mirror8(wd) : wd; m_tdre = 0; end
        else if (tk && !m_tdre) m_tdre = 1;
        if (cwe) begin m_en = cd[0]; m_msb = cd[1]; m_rie = cd[2]; m_tie = cd[3]; end
        @(posedge clk); #1;
        ctrl_we = 0; rx_rd = 0; tx_we = 0; rx_load = 0; tx_take = 0;
        rx_par_err = 0; rx_frm_err = 0;
        check_all();
    endtask

    task automatic idle();
        apply(0, 4'h0, 0, 0, 8'h00, 0, 8'h00, 0, 0, 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        m_full = 0; m_pe = 0; m_ore = 0; m_fre = 0; m_tdre = 1; m_en = 0;
        m_msb = 0; m_rie = 0; m_tie = 0; m_data = 0; m_txd = 0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check("R1", "reset status", status, 16'h0800);
        check("R1", "reset irqs", {14'd0, rx_irq, tx_irq}, 16'd0);
        check("R1", "reset tx_valid", {15'd0, tx_valid}, 16'd0);

        // R7: load while receiver off has no effect
        apply(0, 4'h0, 0, 0, 8'h00, 1, 8'h5A, 1, 1, 0);
        check("R7", "ignored load", status, 16'h0800);

        // enable receiver and both interrupts; R10 tx_irq with empty
        apply(1, 4'b1101, 0, 0, 8'h00, 0, 8'h00, 0, 0, 0);
        check("R10", "tx_irq on empty", {15'd0, tx_irq}, 16'd1);

        // R3: load then read
        apply(0, 4'h0, 0, 0, 8'h00, 1, 8'hA5, 0, 0, 0);
        check("R3", "full after load", {15'd0, status[12]}, 16'd1);
        check("R9", "rx_irq on full", {15'd0, rx_irq}, 16'd1);
        // R4: overrun keeps old byte, drops new error strobes
        apply(0, 4'h0, 0, 0, 8'h00, 1, 8'h3C, 1, 1, 0);
        check("R4", "overrun flag", {15'd0, status[14]}, 16'd1);
        check("R4", "byte kept", {8'd0, rx_rdata}, 16'h00A5);
        check("R4", "strobes dropped", {14'd0, status[15], status[13]}, 16'd0);
        apply(0, 4'h0, 1, 0, 8'h00, 0, 8'h00, 0, 0, 0);
        check("R3", "read clears full", {15'd0, status[12]}, 16'd0);
        check("R6", "overrun sticky", {15'd0, status[14]}, 16'd1);
        // R6: disable clears errors
        apply(1, 4'b1100, 0, 0, 8'h00, 0, 8'h00, 0, 0, 0);
        check("R6", "errors cleared", {13'd0, status[15:13]}, 16'd0);
        apply(1, 4'b1101, 0, 0, 8'h00, 0, 8'h00, 0, 0, 0);
        // parity and framing set on accepted load
        apply(0, 4'h0, 0, 0, 8'h00, 1, 8'h11, 1, 1, 0);
        check("R6", "pe and fre set", {13'd0, status[15:13]}, 16'h0005);
        // R5: read and load together
        apply(0, 4'h0, 1, 0, 8'h00, 1, 8'h22, 0, 0, 0);
        check("R5", "full stays", {15'd0, status[12]}, 16'd1);
        check("R5", "new byte", {8'd0, rx_rdata}, 16'h0022);
        check("R5", "no overrun", {15'd0, status[14]}, 16'd0);
        // R6: clear beats set in same cycle
        apply(1, 4'b1100, 1, 0, 8'h00, 1, 8'h33, 1, 1, 0);
        check("R6", "clear wins", {13'd0, status[15:13]}, 16'd0);
        // R11: MSB-first on both paths
        apply(1, 4'b1111, 0, 0, 8'h00, 0, 8'h00, 0, 0, 0);
        check("R11", "rx mirrored", {8'd0, rx_rdata}, 16'h00CC);
        apply(0, 4'h0, 0, 1, 8'h01, 0, 8'h00, 0, 0, 0);
        check("R11", "tx mirrored", {8'd0, tx_data}, 16'h0080);
        // R8: take and write+take
        apply(0, 4'h0, 0, 1, 8'h03, 0, 8'h00, 0, 0, 1);
        check("R8", "write with take", {15'd0, tx_valid}, 16'd1);
        apply(0, 4'h0, 0, 0, 8'h00, 0, 8'h00, 0, 0, 1);
        check("R8", "take empties", {15'd0, status[11]}, 16'd1);
        idle();

        // constrained random phase
        for (int n = 0; n < 400; n++) begin
            bit cwe;
            bit [3:0] cd;
            cwe = ($urandom % 16) == 0;
            cd  = 4'($urandom);
            if (($urandom % 4) != 0) cd[0] = 1'b1;
            apply(cwe, cd, ($urandom % 3) == 0, ($urandom % 4) == 0, 8'($urandom),
                  ($urandom % 3) == 0, 8'($urandom), ($urandom % 5) == 0,
                  ($urandom % 5) == 0, ($urandom % 3) == 0);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule